// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block supervises a processor core. A counter runs on its own always-on watchdog clock, which keeps running when the core clock is stopped. The counter restarts when it overflows or when the core issues a clear strobe or a sleep-entry strobe. If the counter runs out, the block asks for a reset. When the core is awake, this is a device-reset request. When the core is asleep, it is a wake-up reset request. A configuration enable input set to 0 turns the watchdog off permanently.

One 8-bit prescaler counter is shared between the watchdog and a general-purpose timer. The timer's counting logic is outside this block. A bit in a small control register assigns the prescaler to one of the two. When assigned to the watchdog, the prescaler stretches the timeout (postscaler). When assigned to the timer, it divides the timer's clock-source edges (prescaler). The client that does not own the prescaler runs undivided. A 3-bit ratio field selects one of eight counter taps through an 8-to-1 multiplexer.

Clear and sleep strobes cross from the core clock domain into the watchdog domain through a toggle pulse synchroniser. Timeout events cross back the same way, so that the control register and the timeout status flag can be updated. The watchdog domain runs a three-state machine:
- `WD_OFF`: disabled.
- `WD_AWAKE`: watching a running core.
- `WD_ASLEEP`: watching a sleeping core.

Its transitions are:
- `WD_OFF→WD_AWAKE` or `WD_OFF→WD_ASLEEP` when enabled.
- `WD_AWAKE→WD_ASLEEP` when the synchronised sleep flag rises.
- `WD_ASLEEP→WD_AWAKE` when the flag falls.
- Any state `→WD_OFF` when the enable is low.

Top module: `wdt_shared_ps`

## Requirements
- R1: After power-on reset, the control register reads 0x3F, `to_flag` is 1, and neither request is active. Bits 7:6 read 0, bit 3 is the assignment bit (1 = watchdog), and bits 2:0 are the ratio field.
- R2: With the assignment bit at 1 and ratio field k, a timeout occurs BASE_TICKS·2^k watchdog ticks after the last restart. The same holds after power-on, where the default gives 1:128.
- R3: With the assignment bit at 0, the watchdog times out BASE_TICKS ticks after a restart. `tmr_inc` pulses once per 2^(k+1) rising edges of `tmr_src`.
- R4: With the assignment bit at 1, `tmr_inc` pulses once for every rising edge of `tmr_src`.
- R5: A clear strobe restarts the watchdog counter. It clears the prescaler only while the prescaler is assigned to the watchdog, so a partial timer prescale count survives a clear.
- R6: Clear strobes issued more often than the timeout period keep `rst_req` low.
- R7: A sleep-entry strobe restarts the watchdog counter and the prescaler. A timeout while `slp_flag` is 1 raises `wake_req` and not `rst_req`, even with the core clock stopped.
- R8: A timeout while awake raises `rst_req` as a pulse one watchdog tick wide.
- R9: With `cfg_wdt_en` at 0, neither `rst_req` nor `wake_req` is ever raised.
- R10: A timeout clears `to_flag` to 0 and reloads the control register to 0x3F. A clear strobe sets `to_flag` to 1.
- R11: Changing the assignment bit clears the prescaler counter.
- R12: A write stores `ctl_wdata` into bits 5:0 of the control register, and bits 7:6 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock; may be stopped during sleep |
| clk_wdt | input | 1 | Always-on watchdog tick clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_wdt_en | input | 1 | Static configuration enable for the watchdog |
| ctl_we | input | 1 | Control register write strobe (core domain) |
| ctl_wdata | input | 6 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| clr_stb | input | 1 | Watchdog clear strobe (core domain) |
| slp_stb | input | 1 | Sleep-entry strobe (core domain) |
| slp_flag | input | 1 | Core is in sleep |
| tmr_src | input | 1 | Timer clock source, sampled on clk_wdt |
| tmr_inc | output | 1 | Timer count enable, one clk_wdt tick wide |
| rst_req | output | 1 | Device-reset request pulse (clk_wdt domain) |
| wake_req | output | 1 | Wake-up reset request pulse (clk_wdt domain) |
| to_flag | output | 1 | Timeout status flag, 0 after a timeout |

## Verification
A wrong prescaler state, such as a missed clear on a strobe or on a change of assignment, shows up only at the next tap event. For the watchdog, that is a timeout arriving one or more base periods early. For the timer, `tmr_inc` arrives after too few source edges. The bench therefore measures the tick distance from each strobe to the request and counts `tmr_inc` pulses per group of edges. A wrong state in the state machine shows up as the wrong request line at the very next timeout. A missed reload shows up in `ctl_rdata` and `to_flag` a few core cycles after a timeout.

// File: rtl/wdtps_pkg.sv
package wdtps_pkg;
    parameter int PS_SEL_W = 3;
    localparam int PS_W = 2 ** PS_SEL_W;
    localparam int OPT_W = 6;
    localparam int CTL_W = 8;
    localparam logic [OPT_W-1:0] OPT_RESET = '1;

    typedef enum logic [1:0] {
        WD_OFF    = 2'd0,
        WD_AWAKE  = 2'd1,
        WD_ASLEEP = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic                to_wd;
        logic [PS_SEL_W-1:0] ratio;
    } ps_cfg_t;
endpackage

// File: rtl/wdtps_pulse_sync.sv
module wdtps_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic             tog;
    logic [STAGES:0]  sh;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n)     tog <= 1'b0;
        else if (src_pulse) tog <= ~tog;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) sh <= '0;
        else            sh <= {sh[STAGES-1:0], tog};
    end

    assign dst_pulse = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/wdtps_prescaler.sv
module wdtps_prescaler
    import wdtps_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ps_cfg_t cfg,
    input  logic    wd_evt,
    input  logic    tm_evt,
    input  logic    restart,
    output logic    wd_out,
    output logic    tm_out
);
    logic [PS_W-1:0] cnt;
    logic [PS_W-1:0] tap;
    logic [PS_W-1:0] wd_tap;
    logic            prev_wd;
    logic            swap;
    logic            inc;

    // tap[k] marks the event that carries out of bit k: ratio 2^(k+1)
    generate
        for (genvar k = 0; k < PS_W; k++) begin : g_tap
            assign tap[k] = &cnt[k:0];
        end
    endgenerate

    // watchdog taps are shifted by one so field 0 means no division
    assign wd_tap = {tap[PS_W-2:0], 1'b1};
    assign swap   = (cfg.to_wd != prev_wd);
    assign inc    = cfg.to_wd ? wd_evt : tm_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_wd <= 1'b1;
            cnt     <= '0;
        end else begin
            prev_wd <= cfg.to_wd;
            if (swap || (restart && cfg.to_wd)) cnt <= '0;
            else if (inc)                       cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        if (cfg.to_wd) begin
            wd_out = wd_evt && wd_tap[cfg.ratio] && !swap;
            tm_out = tm_evt;
        end else begin
            wd_out = wd_evt;
            tm_out = tm_evt && tap[cfg.ratio] && !swap;
        end
    end

    p_tm_needs_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tm_out |-> tm_evt);
    p_wd_needs_roll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wd_out |-> wd_evt);
    p_swap_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (cnt == '0));
endmodule

// File: rtl/wdtps_dog.sv
module wdtps_dog
    import wdtps_pkg::*;
#(
    parameter int BASE_TICKS = 18000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic asleep_in,
    input  logic restart,
    input  logic scaled,
    output logic roll,
    output logic rst_req,
    output logic wake_req
);
    localparam int CW = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);

    logic [CW-1:0] wcnt;
    wd_state_e     st, st_nx;

    assign roll = en && !restart && (wcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                wcnt <= '0;
        else if (!en || restart)   wcnt <= '0;
        else if (wcnt == LAST)     wcnt <= '0;
        else                       wcnt <= wcnt + 1'b1;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            WD_OFF:    if (en) st_nx = asleep_in ? WD_ASLEEP : WD_AWAKE;
            WD_AWAKE:  if (!en) st_nx = WD_OFF;
                       else if (asleep_in) st_nx = WD_ASLEEP;
            WD_ASLEEP: if (!en) st_nx = WD_OFF;
                       else if (!asleep_in) st_nx = WD_AWAKE;
            default:   st_nx = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WD_OFF;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            rst_req  <= scaled && (st == WD_AWAKE);
            wake_req <= scaled && (st == WD_ASLEEP);
        end
    end

    p_req_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_req));
    p_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!rst_req && !wake_req));
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= LAST);
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

// File: rtl/wdt_shared_ps.sv
module wdt_shared_ps
    import wdtps_pkg::*;
#(
    parameter int BASE_TICKS = 18000
) (
    input  logic             clk_core,
    input  logic             clk_wdt,
    input  logic             por_n,
    input  logic             cfg_wdt_en,
    input  logic             ctl_we,
    input  logic [OPT_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             clr_stb,
    input  logic             slp_stb,
    input  logic             slp_flag,
    input  logic             tmr_src,
    output logic             tmr_inc,
    output logic             rst_req,
    output logic             wake_req,
    output logic             to_flag
);
    localparam int CFG_W = PS_SEL_W + 1;

    logic [OPT_W-1:0] opt_q;
    logic             to_evt_c;
    logic             restart_w;
    logic [CFG_W-1:0] cfg_s1, cfg_s2;
    logic [1:0]       slp_s;
    logic [2:0]       src_s;
    ps_cfg_t          cfg_w;
    logic             tm_evt, roll, scaled;

    // core domain: control register and timeout status
    always_ff @(posedge clk_core or negedge por_n) begin
        if (!por_n) begin
            opt_q   <= OPT_RESET;
            to_flag <= 1'b1;
        end else begin
            if (to_evt_c)    opt_q <= OPT_RESET;
            else if (ctl_we) opt_q <= ctl_wdata;
            if (to_evt_c)     to_flag <= 1'b0;
            else if (clr_stb) to_flag <= 1'b1;
        end
    end

    assign ctl_rdata = {{(CTL_W-OPT_W){1'b0}}, opt_q};

    // watchdog domain: synchronise quasi-static settings and the timer source
    always_ff @(posedge clk_wdt or negedge por_n) begin
        if (!por_n) begin
            cfg_s1 <= OPT_RESET[CFG_W-1:0];
            cfg_s2 <= OPT_RESET[CFG_W-1:0];
            slp_s  <= '0;
            src_s  <= '0;
        end else begin
            cfg_s1 <= opt_q[CFG_W-1:0];
            cfg_s2 <= cfg_s1;
            slp_s  <= {slp_s[0], slp_flag};
            src_s  <= {src_s[1:0], tmr_src};
        end
    end

    assign cfg_w  = ps_cfg_t'(cfg_s2);
    assign tm_evt = src_s[1] && !src_s[2];

    wdtps_pulse_sync #(.STAGES(2)) u_sync_restart (
        .src_clk   (clk_core),
        .src_rst_n (por_n),
        .src_pulse (clr_stb || slp_stb),
        .dst_clk   (clk_wdt),
        .dst_rst_n (por_n),
        .dst_pulse (restart_w)
    );

    wdtps_pulse_sync #(.STAGES(2)) u_sync_timeout (
        .src_clk   (clk_wdt),
        .src_rst_n (por_n),
        .src_pulse (rst_req || wake_req),
        .dst_clk   (clk_core),
        .dst_rst_n (por_n),
        .dst_pulse (to_evt_c)
    );

    wdtps_prescaler u_ps (
        .clk     (clk_wdt),
        .rst_n   (por_n),
        .cfg     (cfg_w),
        .wd_evt  (roll),
        .tm_evt  (tm_evt),
        .restart (restart_w),
        .wd_out  (scaled),
        .tm_out  (tmr_inc)
    );

    wdtps_dog #(.BASE_TICKS(BASE_TICKS)) u_dog (
        .clk       (clk_wdt),
        .rst_n     (por_n),
        .en        (cfg_wdt_en),
        .asleep_in (slp_s[1]),
        .restart   (restart_w),
        .scaled    (scaled),
        .roll      (roll),
        .rst_req   (rst_req),
        .wake_req  (wake_req)
    );

    p_timeout_reload_r10: assert property (@(posedge clk_core) disable iff (!por_n)
        to_evt_c |=> (!to_flag && opt_q == OPT_RESET));
    p_clear_sets_flag_r10: assert property (@(posedge clk_core) disable iff (!por_n)
        (clr_stb && !to_evt_c) |=> to_flag);
endmodule

// File: tb/tb_wdt_shared_ps.sv
module tb_wdt_shared_ps;
    localparam int BASE = 8;

    logic       clk_raw = 1'b0, core_run = 1'b1, clk_wdt = 1'b0;
    logic       clk_core;
    logic       por_n = 1'b0, cfg_wdt_en = 1'b1, ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       clr_stb = 1'b0, slp_stb = 1'b0, slp_flag = 1'b0, tmr_src = 1'b0;
    logic       tmr_inc, rst_req, wake_req, to_flag;

    int total = 0, fails = 0;
    int inc_cnt = 0, rst_cnt = 0, wake_cnt = 0;
    bit done = 1'b0;

    always #2 clk_raw = ~clk_raw;
    always #7 clk_wdt = ~clk_wdt;
    assign clk_core = clk_raw & core_run;

    wdt_shared_ps #(.BASE_TICKS(BASE)) dut (
        .clk_core(clk_core), .clk_wdt(clk_wdt), .por_n(por_n),
        .cfg_wdt_en(cfg_wdt_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .clr_stb(clr_stb), .slp_stb(slp_stb),
        .slp_flag(slp_flag), .tmr_src(tmr_src), .tmr_inc(tmr_inc),
        .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag)
    );

    always @(posedge clk_wdt) begin
        #1;
        if (tmr_inc)  inc_cnt++;
        if (rst_req)  rst_cnt++;
        if (wake_req) wake_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic core_cyc(input int n);
        repeat (n) @(negedge clk_raw);
    endtask

    task automatic wdt_cyc(input int n);
        repeat (n) @(negedge clk_wdt);
    endtask

    task automatic write_opt(input logic [5:0] v);
        @(negedge clk_raw); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk_raw); ctl_we = 1'b0;
    endtask

    task automatic strobe_clr();
        @(negedge clk_raw); clr_stb = 1'b1;
        @(negedge clk_raw); clr_stb = 1'b0;
    endtask

    task automatic strobe_slp();
        @(negedge clk_raw); slp_stb = 1'b1;
        @(negedge clk_raw); slp_stb = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            tmr_src = 1'b1; wdt_cyc(4);
            tmr_src = 1'b0; wdt_cyc(4);
        end
        wdt_cyc(4);
    endtask

    // ticks until a request is seen; wake reports which line fired
    task automatic measure(output int n, output bit wake);
        n = 0; wake = 1'b0;
        while (n < 5000) begin
            @(negedge clk_wdt);
            n++;
            if (rst_req || wake_req) begin
                wake = wake_req;
                break;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 rdata", ctl_rdata, 8'h3F);
        chk("R1 to_flag", to_flag, 1);
        chk("R1 no request", rst_req | wake_req, 0);
    endtask

    task automatic t_first_timeout();
        int n; bit w;
        measure(n, w);
        chk_rng("R2 default 1:128 period", n, BASE*128 - 4, BASE*128 + 6);
        chk("R8 awake gives device reset", w, 0);
        @(negedge clk_wdt);
        chk("R8 one tick pulse", rst_req, 0);
        core_cyc(10);
        chk("R10 to_flag cleared", to_flag, 0);
        chk("R10 reload", ctl_rdata, 8'h3F);
    endtask

    task automatic t_ratio();
        int n; bit w;
        write_opt(6'h3A);
        wdt_cyc(6);
        strobe_clr();
        core_cyc(4);
        chk("R10 clear sets to_flag", to_flag, 1);
        wdt_cyc(20);
        strobe_clr();
        measure(n, w);
        chk_rng("R2 R5 ratio 1:4 after clear", n, BASE*4 + 1, BASE*4 + 6);
        chk("R8 request line", w, 0);
        core_cyc(10);
    endtask

    task automatic t_unscaled_wd();
        int n; bit w;
        write_opt(6'h32);
        strobe_clr();
        measure(n, w);
        chk_rng("R3 watchdog unscaled", n, BASE + 1, BASE + 6);
        core_cyc(10);
    endtask

    task automatic t_keepalive();
        int n; bit w; int r0;
        write_opt(6'h39);
        wdt_cyc(6);
        r0 = rst_cnt;
        for (int i = 0; i < 20; i++) begin
            strobe_clr();
            wdt_cyc(9);
        end
        chk("R6 clears hold off reset", rst_cnt, r0);
        strobe_clr();
        measure(n, w);
        chk_rng("R2 ratio 1:2", n, BASE*2 + 1, BASE*2 + 6);
        core_cyc(10);
    endtask

    task automatic t_sleep();
        int n; bit w; int r0;
        write_opt(6'h39);
        wdt_cyc(6);
        strobe_clr();
        slp_flag = 1'b1;
        wdt_cyc(12);
        r0 = rst_cnt;
        strobe_slp();
        core_run = 1'b0;
        measure(n, w);
        chk_rng("R7 sleep restart period", n, BASE*2 + 1, BASE*2 + 6);
        chk("R7 wake request", w, 1);
        wdt_cyc(2);
        chk("R7 no device reset", rst_cnt, r0);
        @(negedge clk_raw); core_run = 1'b1;
        slp_flag = 1'b0;
        core_cyc(10);
        chk("R10 to_flag after wake", to_flag, 0);
        chk("R10 reload after wake", ctl_rdata, 8'h3F);
    endtask

    task automatic t_timer();
        int i0, r0, w0;
        cfg_wdt_en = 1'b0;
        wdt_cyc(4);
        r0 = rst_cnt; w0 = wake_cnt;
        write_opt(6'h31);
        wdt_cyc(6);
        i0 = inc_cnt; pulses(3);
        chk("R3 timer 1:4 not yet", inc_cnt - i0, 0);
        pulses(1);
        chk("R3 timer 1:4 fires", inc_cnt - i0, 1);
        i0 = inc_cnt; pulses(2);
        strobe_clr(); wdt_cyc(6);
        pulses(1);
        chk("R5 clear keeps timer count", inc_cnt - i0, 0);
        pulses(1);
        chk("R5 timer fires on 4th edge", inc_cnt - i0, 1);
        write_opt(6'h30); wdt_cyc(6);
        i0 = inc_cnt; pulses(4);
        chk("R3 timer 1:2", inc_cnt - i0, 2);
        write_opt(6'h39); wdt_cyc(6);
        i0 = inc_cnt; pulses(3);
        chk("R4 timer unscaled", inc_cnt - i0, 3);
        write_opt(6'h31); wdt_cyc(6);
        pulses(2);
        write_opt(6'h39); wdt_cyc(6);
        i0 = inc_cnt; pulses(1);
        chk("R4 single edge", inc_cnt - i0, 1);
        write_opt(6'h31); wdt_cyc(6);
        i0 = inc_cnt; pulses(3);
        chk("R11 swap cleared prescaler", inc_cnt - i0, 0);
        pulses(1);
        chk("R11 fires on 4th edge", inc_cnt - i0, 1);
        wdt_cyc(BASE*128*2);
        chk("R9 no reset while disabled", rst_cnt, r0);
        chk("R9 no wake while disabled", wake_cnt, w0);
    endtask

    task automatic t_write();
        write_opt(6'h15);
        core_cyc(2);
        chk("R12 readback", ctl_rdata, 8'h15);
    endtask

    initial begin
        core_cyc(5);
        por_n = 1'b1;
        t_reset();
        t_first_timeout();
        t_ratio();
        t_unscaled_wd();
        t_keepalive();
        t_sleep();
        t_timer();
        t_write();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule